// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns their full `2*WIDTH`-bit signed product. It works through the multiplier one bit per clock. On each step it inspects the lowest multiplier bit together with the bit that was shifted out on the previous step. From that pair it either adds the multiplicand to the running upper half, subtracts it, or leaves the upper half alone. It then shifts the whole working register right by one place, keeping the sign.

A caller places both operands on the inputs and pulses `start` while the block is idle. The block captures the operands on that edge and raises `busy`. Exactly `WIDTH` clock cycles later it drops `busy`, pulses `done` for one cycle and presents the product on a registered output. The product stays there until the next multiply completes. A `start` pulse that arrives while a multiply is under way is ignored, and so is any change of the operand inputs during that time.

Top module: `booth_mult_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `busy` and `done` are 0 and `product` is all zeros.
- R2: A high `start` sampled at a clock edge while `busy` is 0 captures `mcand` and `mplier` and makes `busy` read 1 after that edge.
- R3: `done` is high for exactly one cycle. It first reads 1 after the WIDTH-th clock edge following the capturing edge, and `busy` reads 0 from that same point.
- R4: After `done`, `product` equals the signed two's-complement product of the captured `mcand` and `mplier`, as a 2*WIDTH-bit two's-complement value.
- R5: The most negative value times the most negative value gives the positive product 2^(2*WIDTH-2).
- R6: A `start` pulse sampled while `busy` is 1 neither restarts nor shortens the running multiply, and it does not change its result.
- R7: `product` holds its value in every cycle in which no multiply completes.
- R8: Changes on `mcand` and `mplier` while `busy` is 1 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiply when the block is idle |
| mcand | input | WIDTH | Signed multiplicand, captured at start |
| mplier | input | WIDTH | Signed multiplier, captured at start |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse when the product is updated |
| product | output | 2*WIDTH | Signed product of the last completed multiply |

## Verification
A 5-bit instance is run over every pair of operands, so every sequence of add, subtract and hold steps that a 5-bit multiplier can produce is covered. This includes the negative-by-negative extreme that overflows a plain upper-half register. A 16-bit instance takes seeded random pairs plus directed values: zero, one, minus one, the most positive and most negative values, and alternating bit patterns. Alternating patterns force an add or subtract on every step, and long runs of ones force nearly all holds. A restart pulse and operand changes are injected mid-run to tell a correctly latched operation from one that reloads or reads its inputs live. The product is watched across idle cycles to confirm that it holds.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    BOOTH_HOLD = 2'd0,
    BOOTH_ADD  = 2'd1,
    BOOTH_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recoder.sv
// Picks the action for one step from the current low multiplier bit and
// the bit shifted out on the previous step.
module booth_recoder
  import booth_pkg::*;
(
  input  logic      q_lsb,
  input  logic      q_prev,
  output booth_op_e op
);
  always_comb begin
    unique case ({q_lsb, q_prev})
      2'b10:   op = BOOTH_SUB;  // first one of a run
      2'b01:   op = BOOTH_ADD;  // first zero after a run
      default: op = BOOTH_HOLD; // inside a run of equal bits
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
// Adds, subtracts or passes the multiplicand into a one-bit-wider
// accumulator, so the most negative multiplicand cannot overflow (R5).
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int AW = WIDTH + 1
) (
  input  logic [AW-1:0]    acc_in,
  input  logic [WIDTH-1:0] mcand,
  input  booth_op_e        op,
  output logic [AW-1:0]    acc_out
);
  logic [AW-1:0] mc_ext;
  assign mc_ext = {mcand[WIDTH-1], mcand};

  always_comb begin
    unique case (op)
      BOOTH_ADD: acc_out = acc_in + mc_ext;
      BOOTH_SUB: acc_out = acc_in + ~mc_ext + AW'(1);
      default:   acc_out = acc_in;
    endcase
  end
endmodule

// File: rtl/booth_ashr.sv
// Arithmetic right shift by one across accumulator, multiplier and the
// trailing bit; the accumulator sign is repeated.
module booth_ashr #(
  parameter int WIDTH = 16,
  localparam int AW = WIDTH + 1
) (
  input  logic [AW-1:0]    acc_in,
  input  logic [WIDTH-1:0] q_in,
  output logic [AW-1:0]    acc_out,
  output logic [WIDTH-1:0] q_out,
  output logic             q_prev_out
);
  assign acc_out    = {acc_in[AW-1], acc_in[AW-1:1]};
  assign q_out      = {acc_in[0], q_in[WIDTH-1:1]};
  assign q_prev_out = q_in[0];
endmodule

// File: rtl/booth_ctrl.sv
// Step counter and handshake. Loads on an idle start, runs WIDTH steps,
// then pulses done.
module booth_ctrl #(
  parameter int WIDTH = 16,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  logic [CW-1:0] steps_left;

  assign load = start && !busy;             // R2, R6: ignored while busy
  assign step = busy;
  assign last = busy && (steps_left == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      steps_left <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy       <= 1'b1;
        steps_left <= CW'(WIDTH);
      end else if (busy) begin
        steps_left <= steps_left - CW'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;                     // R3
        end
      end
    end
  end
endmodule

// File: rtl/booth_mult_seq.sv
module booth_mult_seq
  import booth_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int AW = WIDTH + 1,
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] mplier,
  output logic             busy,
  output logic             done,
  output logic [PW-1:0]    product
);
  logic [WIDTH-1:0] mc_q;
  logic [AW-1:0]    acc_q;
  logic [WIDTH-1:0] mp_q;
  logic             prev_q;

  logic             load, step, last;
  booth_op_e        op;
  logic [AW-1:0]    acc_sum;
  logic [AW-1:0]    acc_sh;
  logic [WIDTH-1:0] mp_sh;
  logic             prev_sh;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .step(step), .last(last),
    .busy(busy), .done(done)
  );

  booth_recoder u_rec (
    .q_lsb(mp_q[0]), .q_prev(prev_q), .op(op)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_add (
    .acc_in(acc_q), .mcand(mc_q), .op(op), .acc_out(acc_sum)
  );

  booth_ashr #(.WIDTH(WIDTH)) u_shr (
    .acc_in(acc_sum), .q_in(mp_q),
    .acc_out(acc_sh), .q_out(mp_sh), .q_prev_out(prev_sh)
  );

  // Working registers: operands captured only on load (R8).
  always_ff @(posedge clk) begin
    if (rst) begin
      mc_q   <= '0;
      acc_q  <= '0;
      mp_q   <= '0;
      prev_q <= 1'b0;
    end else if (load) begin
      mc_q   <= mcand;
      acc_q  <= '0;
      mp_q   <= mplier;
      prev_q <= 1'b0;
    end else if (step) begin
      acc_q  <= acc_sh;
      mp_q   <= mp_sh;
      prev_q <= prev_sh;
    end
  end

  // Registered result, updated only on the final step (R4, R7).
  always_ff @(posedge clk) begin
    if (rst) begin
      product <= '0;
    end else if (last) begin
      product <= {acc_sh[WIDTH-1:0], mp_sh};
    end
  end
endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int WIDTH = 16,
  localparam int PW = 2 * WIDTH,
  localparam int KW = $clog2(WIDTH + 1) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [PW-1:0] product
);
  logic [KW-1:0] run_cycles;

  always_ff @(posedge clk) begin
    if (rst) run_cycles <= '0;
    else if (start && !busy) run_cycles <= '0;
    else if (busy) run_cycles <= run_cycles + KW'(1);
  end

  p_busy_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_no_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !done);

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_cycles == KW'(WIDTH)));

  p_restart_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (start && busy && (run_cycles < KW'(WIDTH - 1))) |=> busy);

  p_product_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));
endmodule

bind booth_mult_seq booth_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .start(start),
  .busy(busy), .done(done), .product(product)
);

// File: tb/tb_booth_mult_seq.sv
`timescale 1ns/1ps
module tb_booth_mult_seq;
  localparam int W = 16;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic           st16 = 1'b0, st5 = 1'b0;
  logic [W-1:0]   a16 = '0, b16 = '0;
  logic [N-1:0]   a5 = '0, b5 = '0;
  logic           busy16, done16, busy5, done5;
  logic [2*W-1:0] prod16;
  logic [2*N-1:0] prod5;

  int checks = 0;
  int bad = 0;

  booth_mult_seq #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .start(st16), .mcand(a16), .mplier(b16),
    .busy(busy16), .done(done16), .product(prod16)
  );

  booth_mult_seq #(.WIDTH(N)) dut_w5 (
    .clk(clk), .rst(rst), .start(st5), .mcand(a5), .mplier(b5),
    .busy(busy5), .done(done5), .product(prod5)
  );

  function automatic logic [2*W-1:0] ref16(logic [W-1:0] x, logic [W-1:0] y);
    longint p;
    p = longint'($signed(x)) * longint'($signed(y));
    return p[2*W-1:0];
  endfunction

  function automatic logic [2*N-1:0] ref5(logic [N-1:0] x, logic [N-1:0] y);
    longint p;
    p = longint'($signed(x)) * longint'($signed(y));
    return p[2*N-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  // Multiply on the 16-bit instance; optional mid-run disturbance (R6, R8).
  task automatic mul16(input logic [W-1:0] x, input logic [W-1:0] y, input bit disturb);
    int k;
    logic [2*W-1:0] exp;
    exp = ref16(x, y);
    @(negedge clk);
    a16 = x; b16 = y; st16 = 1'b1;
    @(negedge clk);
    st16 = 1'b0;
    check(busy16 == 1'b1, "R2", longint'(busy16), 1);
    k = 0;
    while (!done16 && k < 100) begin
      @(negedge clk);
      k++;
      if (disturb && k == 3) begin
        st16 = 1'b1; a16 = ~x; b16 = x ^ y;  // R6 restart, R8 new operands
      end else if (disturb && k == 4) begin
        st16 = 1'b0;
      end
    end
    check(k == W, "R3 latency", longint'(k), longint'(W));
    check(!busy16, "R3 busy clear", longint'(busy16), 0);
    check(prod16 == exp, disturb ? "R6 R8 product" : "R4 product",
          longint'(prod16), longint'(exp));
    @(negedge clk);
    check(!done16, "R3 pulse width", longint'(done16), 0);
  endtask

  task automatic mul5(input logic [N-1:0] x, input logic [N-1:0] y);
    int k;
    logic [2*N-1:0] exp;
    exp = ref5(x, y);
    @(negedge clk);
    a5 = x; b5 = y; st5 = 1'b1;
    @(negedge clk);
    st5 = 1'b0;
    k = 0;
    while (!done5 && k < 50) begin
      @(negedge clk);
      k++;
    end
    check(k == N && prod5 == exp, "R4 exhaustive w5",
          longint'(prod5), longint'(exp));
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [2*W-1:0] held;
    int unsigned seed;
    seed = 32'd1357;
    void'($urandom(seed));

    repeat (3) @(negedge clk);
    check(!busy16 && !done16 && prod16 == '0, "R1 in reset", longint'(prod16), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy16 && !done16 && prod16 == '0, "R1 after reset", longint'(prod16), 0);
    check(!busy5 && !done5 && prod5 == '0, "R1 w5", longint'(prod5), 0);

    // R5: extreme corners
    mul16(16'h8000, 16'h8000, 1'b0);
    check(prod16 == 32'h4000_0000, "R5 min*min", longint'(prod16), 32'h4000_0000);
    mul5(5'h10, 5'h10);
    check(prod5 == 10'h100, "R5 min*min w5", longint'(prod5), 10'h100);

    // Directed patterns (R4)
    mul16(16'h0000, 16'h1234, 1'b0);
    mul16(16'h0001, 16'hFFFF, 1'b0);
    mul16(16'hFFFF, 16'hFFFF, 1'b0);
    mul16(16'h7FFF, 16'h8000, 1'b0);
    mul16(16'h7FFF, 16'h7FFF, 1'b0);
    mul16(16'h5555, 16'hAAAA, 1'b0);
    mul16(16'hAAAA, 16'h5555, 1'b0);
    mul16(16'h1234, 16'h7FF0, 1'b0);

    // R7: product holds while idle
    held = prod16;
    repeat (5) @(negedge clk);
    check(prod16 == held && !done16, "R7 hold idle", longint'(prod16), longint'(held));

    // R6, R8: disturbance during run
    mul16(16'h00C3, 16'hFF9A, 1'b1);
    mul16(16'h8000, 16'h7FFF, 1'b1);

    // R4: random pairs
    for (int i = 0; i < 400; i++) begin
      mul16(W'($urandom), W'($urandom), 1'b0);
    end

    // R4, R5: exhaustive 5-bit
    for (int i = 0; i < (1 << N); i++) begin
      for (int j = 0; j < (1 << N); j++) begin
        mul5(N'(i), N'(j));
      end
    end

    finish_run();
  end
endmodule